// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for a two-channel audio serial link. Every register in it runs on the master clock. In master mode a prescaler divides the master clock down to the bit clock, and a bit counter divides the bit clock down to the frame clock. Both clocks then leave the chip through an output enable. In slave mode the block turns the output enable off. It takes the two clocks from the external device, which must already be synchronised, and passes them inward.

The inward copies are normalised. Their rising edge is the sampling edge, and a frame level of 0 means the left channel. Configuration comes in as static inputs: a global enable, the master/slave choice, the divider selects, separate polarity controls for each clock, and a free-run control that turns bit-clock gating on or off. A new divider select takes effect at the next frame boundary. While the block is disabled or in slave mode, a new select takes effect at once.

Top module: `audio_clkgen`

## Requirements
- R1: `bdiv_sel_i` sets the bit-clock period in master clocks: 0 gives 2 and 1 gives 4. Before inversion each period starts with its low half and ends with its high half.
- R2: `fdiv_sel_i` sets the frame length in bit periods: 0 gives 32, 1 gives 64, 2 gives 128, and 3 also gives 128.
- R3: The frame clock changes level exactly halfway through the frame, so each channel gets half the frame. The first half is the left channel, and `fclk_int_o` is 0 during it. The frame clock only changes at the start of a bit period, while the bit clock is in its low half.
- R4: `fclk_inv_i`=0 holds `fclk_o` low during the left half; `fclk_inv_i`=1 holds it high.
- R5: `bclk_inv_i`=1 inverts `bclk_o` and also its idle level. `bclk_int_o` stays normalised.
- R6: With `free_run_i`=1 the bit clock runs all the time. With `free_run_i`=0 it runs only during bit periods whose opening edge sampled `slot_active_i`=1, and it holds its idle level otherwise. The frame clock is not affected.
- R7: While running, a new divider select is applied only at the edge that ends the last bit period of a frame. While disabled or in slave mode, a new select is applied on every edge.
- R8: One edge after `en_i` is sampled low, the outputs are idle: `bclk_o`=`bclk_inv_i`, `fclk_o`=`fclk_inv_i`, `clk_oe_o`=0, and both inward clocks are 0. The edge that enables the block starts a fresh left half in the low phase of the bit clock.
- R9: One edge after `en_i`=1 and `master_i`=0 are sampled, `clk_oe_o` is 0 and the outgoing pins are idle. The inward clocks then equal `ext_bclk_i ^ bclk_inv_i` and `ext_fclk_i ^ fclk_inv_i`.
- R10: During reset the counters are zero, `clk_oe_o` is 0, and the outgoing clocks sit at their idle polarity.
- R11: One edge after `en_i`=1 and `master_i`=1 are sampled, `clk_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| master_i | input | 1 | 1: generate clocks, 0: accept external clocks |
| bdiv_sel_i | input | 1 | Master-to-bit ratio select (0: 2, 1: 4) |
| fdiv_sel_i | input | 2 | Bits per frame select (0: 32, 1: 64, 2/3: 128) |
| bclk_inv_i | input | 1 | Bit clock polarity |
| fclk_inv_i | input | 1 | Frame clock level during the left half |
| free_run_i | input | 1 | 1: bit clock runs all the time |
| slot_active_i | input | 1 | Data slot active, used when not free-running |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock pin |
| fclk_o | output | 1 | Frame clock pin |
| clk_oe_o | output | 1 | Pin drive enable |
| bclk_int_o | output | 1 | Normalised inward bit clock |
| fclk_int_o | output | 1 | Normalised inward frame clock (0 = left) |

## Verification
Two functions can land on the same master-clock edge: loading a new divider select and closing a frame. The bench provokes this by waiting until its reference model is on the last master cycle of a frame, then changing the select just before that edge. It also changes selects in the middle of a frame and while the block is disabled. The reference model is compared with every output on every cycle. Separate measurements of half-frame lengths and bit periods then confirm that the old ratio holds until the boundary and the new one holds after it.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int MAX_RATIO = 4;
  localparam int MAX_FRAME = 128;
  localparam int PRE_W     = $clog2(MAX_RATIO);
  localparam int BIT_W     = $clog2(MAX_FRAME);
  localparam int FSEL_W    = 2;

  function automatic int bit_ratio(input logic sel);
    return sel ? 4 : 2;
  endfunction

  function automatic int frame_len(input logic [FSEL_W-1:0] sel);
    case (sel)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/acg_prescale.sv
module acg_prescale
  import acg_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic bsel_i,
  output logic wrap_o,
  output logic phase_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last, half;

  assign last    = PW'(bit_ratio(bsel_i) - 1);
  assign half    = PW'(bit_ratio(bsel_i) / 2);
  assign wrap_o  = adv_i && (cnt_q == last);
  assign phase_o = (cnt_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!adv_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/acg_frame_cnt.sv
module acg_frame_cnt
  import acg_pkg::*;
#(
  parameter int BW = BIT_W,
  parameter int SW = FSEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          pre_wrap_i,
  input  logic          bsel_i,
  input  logic [SW-1:0] fsel_i,
  input  logic          gate_i,
  output logic          bsel_o,
  output logic          half_o,
  output logic          gate_o
);
  logic [BW-1:0] bit_q;
  logic [SW-1:0] fsel_q;
  logic          bsel_q, gate_q;
  logic [BW-1:0] last, mid;
  logic          bnd, reload;

  assign last   = BW'(frame_len(fsel_q) - 1);
  assign mid    = BW'(frame_len(fsel_q) / 2);
  assign bnd    = pre_wrap_i && (bit_q == last);
  // selections shadowed: only swapped at frame boundary while running
  assign reload = !adv_i || bnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      fsel_q <= '0;
      bsel_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      if (reload)          bit_q <= '0;
      else if (pre_wrap_i) bit_q <= bit_q + 1'b1;
      if (reload) begin
        bsel_q <= bsel_i;
        fsel_q <= fsel_i;
      end
      if (!adv_i || pre_wrap_i) gate_q <= gate_i;
    end
  end

  assign bsel_o = bsel_q;
  assign half_o = (bit_q >= mid);
  assign gate_o = gate_q;
endmodule

// File: rtl/acg_out_mux.sv
module acg_out_mux (
  input  logic started_i,
  input  logic slave_i,
  input  logic bphase_i,
  input  logic gate_i,
  input  logic fhalf_i,
  input  logic binv_i,
  input  logic finv_i,
  input  logic ext_b_i,
  input  logic ext_f_i,
  output logic bclk_o,
  output logic fclk_o,
  output logic oe_o,
  output logic bint_o,
  output logic fint_o
);
  logic braw;

  assign braw = gate_i & bphase_i;

  always_comb begin
    if (started_i) begin
      bclk_o = braw ^ binv_i;
      fclk_o = fhalf_i ^ finv_i;
      oe_o   = 1'b1;
      bint_o = braw;
      fint_o = fhalf_i;
    end else begin
      bclk_o = binv_i;
      fclk_o = finv_i;
      oe_o   = 1'b0;
      bint_o = slave_i & (ext_b_i ^ binv_i);
      fint_o = slave_i & (ext_f_i ^ finv_i);
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int PRE_CW = PRE_W,
  parameter int BIT_CW = BIT_W,
  parameter int SEL_W  = FSEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             master_i,
  input  logic             bdiv_sel_i,
  input  logic [SEL_W-1:0] fdiv_sel_i,
  input  logic             bclk_inv_i,
  input  logic             fclk_inv_i,
  input  logic             free_run_i,
  input  logic             slot_active_i,
  input  logic             ext_bclk_i,
  input  logic             ext_fclk_i,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             clk_oe_o,
  output logic             bclk_int_o,
  output logic             fclk_int_o
);
  logic en_q, mst_q;
  logic started, adv;
  logic pre_wrap, bphase, bsel_act, fhalf, gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      mst_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      mst_q <= master_i;
    end
  end

  assign started = en_q & mst_q;
  // first enabled edge holds counters at zero so output starts in low phase
  assign adv     = started & en_i & master_i;

  acg_prescale #(.PW(PRE_CW)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .bsel_i  (bsel_act),
    .wrap_o  (pre_wrap),
    .phase_o (bphase)
  );

  acg_frame_cnt #(.BW(BIT_CW), .SW(SEL_W)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .pre_wrap_i (pre_wrap),
    .bsel_i     (bdiv_sel_i),
    .fsel_i     (fdiv_sel_i),
    .gate_i     (free_run_i | slot_active_i),
    .bsel_o     (bsel_act),
    .half_o     (fhalf),
    .gate_o     (gate)
  );

  acg_out_mux u_mux (
    .started_i (started),
    .slave_i   (en_q & ~mst_q),
    .bphase_i  (bphase),
    .gate_i    (gate),
    .fhalf_i   (fhalf),
    .binv_i    (bclk_inv_i),
    .finv_i    (fclk_inv_i),
    .ext_b_i   (ext_bclk_i),
    .ext_f_i   (ext_fclk_i),
    .bclk_o    (bclk_o),
    .fclk_o    (fclk_o),
    .oe_o      (clk_oe_o),
    .bint_o    (bclk_int_o),
    .fint_o    (fclk_int_o)
  );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic bclk_inv_i,
  input logic fclk_inv_i,
  input logic ext_bclk_i,
  input logic ext_fclk_i,
  input logic bclk_o,
  input logic fclk_o,
  input logic clk_oe_o,
  input logic bclk_int_o,
  input logic fclk_int_o
);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bclk_o == bclk_inv_i && fclk_o == fclk_inv_i && !clk_oe_o
               && !bclk_int_o && !fclk_int_o));

  p_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i) |=> clk_oe_o);

  p_slave_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !master_i) |=> (!clk_oe_o
      && bclk_int_o == (ext_bclk_i ^ bclk_inv_i)
      && fclk_int_o == (ext_fclk_i ^ fclk_inv_i)));

  p_frame_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_oe_o && $past(clk_oe_o) && !$stable(fclk_int_o)) |-> !bclk_int_o);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (.*);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, master = 0, bsel = 0, binv = 0, finv = 0, free_run = 0, slot = 0;
  logic ext_b = 0, ext_f = 0;
  logic [1:0] fsel = 0;
  logic bclk_o, fclk_o, clk_oe_o, bclk_int_o, fclk_int_o;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  audio_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master),
    .bdiv_sel_i(bsel), .fdiv_sel_i(fsel), .bclk_inv_i(binv), .fclk_inv_i(finv),
    .free_run_i(free_run), .slot_active_i(slot), .ext_bclk_i(ext_b), .ext_fclk_i(ext_f),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe_o(clk_oe_o),
    .bclk_int_o(bclk_int_o), .fclk_int_o(fclk_int_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model
  int m_en_q, m_mst_q, m_pre, m_bit, m_r, m_f, m_gate;
  function automatic int ratio_of(input logic s); return s ? 4 : 2; endfunction
  function automatic int flen_of(input logic [1:0] s);
    if (s == 2'd0) return 32;
    if (s == 2'd1) return 64;
    return 128;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en_q = 0; m_mst_q = 0; m_pre = 0; m_bit = 0; m_r = 2; m_f = 32; m_gate = 0;
    end else begin
      int run_in, was;
      run_in = en && master;
      was = m_en_q && m_mst_q;
      if (!run_in || !was) begin
        m_pre = 0; m_bit = 0; m_r = ratio_of(bsel); m_f = flen_of(fsel);
        m_gate = free_run || slot;
      end else if (m_pre == m_r - 1) begin
        m_pre = 0;
        m_gate = free_run || slot;
        if (m_bit == m_f - 1) begin
          m_bit = 0; m_r = ratio_of(bsel); m_f = flen_of(fsel);
        end else m_bit++;
      end else m_pre++;
      m_en_q = en; m_mst_q = master;
    end
  end

  always @(negedge clk) begin
    int eb, ef, eoe, ebi, efi;
    if (m_en_q && m_mst_q) begin
      ebi = (m_gate && (m_pre >= m_r / 2)) ? 1 : 0;
      efi = (m_bit >= m_f / 2) ? 1 : 0;
      eb = ebi ^ binv; ef = efi ^ finv; eoe = 1;
    end else begin
      eb = binv; ef = finv; eoe = 0;
      ebi = (m_en_q && !m_mst_q) ? (ext_b ^ binv) : 0;
      efi = (m_en_q && !m_mst_q) ? (ext_f ^ finv) : 0;
    end
    check(cur_req, "bclk_o", bclk_o, eb);
    check(cur_req, "fclk_o", fclk_o, ef);
    check(cur_req, "clk_oe_o", clk_oe_o, eoe);
    check(cur_req, "bclk_int_o", bclk_int_o, ebi);
    check(cur_req, "fclk_int_o", fclk_int_o, efi);
  end

  task automatic go(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sync_fclk();
    logic p;
    p = fclk_int_o;
    do @(negedge clk); while (fclk_int_o == p);
  endtask

  task automatic half_len(input string req, input int exp);
    logic p;
    int n;
    p = fclk_int_o; n = 0;
    do begin @(negedge clk); n++; end while (fclk_int_o == p);
    check(req, "half_frame_cycles", n, exp);
    #1;
  endtask

  task automatic bclk_period(input string req, input int exp);
    logic p;
    int n;
    do begin p = bclk_int_o; @(negedge clk); end while (!(bclk_int_o && !p));
    n = 0;
    do begin p = bclk_int_o; @(negedge clk); n++; end while (!(bclk_int_o && !p));
    check(req, "bclk_period", n, exp);
    #1;
  endtask

  task automatic wait_last();
    while (!(m_en_q && m_mst_q && m_pre == m_r - 1 && m_bit == m_f - 1)) go(1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    int bad;
    // R10 reset state
    go(3);
    check("R10", "oe_in_reset", clk_oe_o, 0);
    check("R10", "bclk_idle", bclk_o, 0);
    check("R10", "fclk_idle", fclk_o, 0);
    binv = 1; finv = 1;
    go(1);
    check("R10", "bclk_idle_inv", bclk_o, 1);
    check("R10", "fclk_idle_inv", fclk_o, 1);
    binv = 0; finv = 0;
    rst_n = 1;
    go(2);

    // R1 R2 R3 R11 basic master operation
    cur_req = "R1";
    free_run = 1; master = 1; en = 1;
    go(1);
    check("R11", "oe_master", clk_oe_o, 1);
    check("R3", "left_first", fclk_int_o, 0);
    sync_fclk();
    half_len("R3", 32);
    half_len("R2", 32);
    bclk_period("R1", 2);

    // R7 mid-frame change: old ratio holds until boundary
    cur_req = "R7";
    while (fclk_int_o != 0) go(1);
    go(5);
    bsel = 1; fsel = 2'd1;
    sync_fclk();
    half_len("R7", 32);
    half_len("R7", 128);
    bclk_period("R1", 4);

    // R7 change on the very edge that closes the frame
    wait_last();
    fsel = 2'd2;
    sync_fclk();
    half_len("R7", 256);

    // R2 code 3 behaves as 128
    cur_req = "R2";
    wait_last();
    bsel = 0; fsel = 2'd3;
    sync_fclk();
    half_len("R2", 128);

    // R4 R5 polarity
    cur_req = "R4";
    binv = 1; finv = 1;
    go(1);
    while (fclk_int_o != 0) go(1);
    check("R4", "fclk_high_left", fclk_o, 1);
    check("R5", "bclk_inverted", bclk_o, !bclk_int_o);
    go(300);

    // R6 gating
    cur_req = "R6";
    free_run = 0; lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      slot = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      go(1);
    end
    wait_last();
    slot = 0;
    go(2);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      if (bclk_int_o) bad++;
      go(1);
    end
    check("R6", "gated_bclk_high_cycles", bad, 0);
    sync_fclk();
    half_len("R6", 128);
    slot = 1; free_run = 1;

    // R8 disable and restart; R7 immediate while disabled
    cur_req = "R8";
    go(37);
    en = 0;
    go(1);
    check("R8", "oe_off", clk_oe_o, 0);
    check("R8", "bclk_idle", bclk_o, binv);
    check("R8", "fclk_idle", fclk_o, finv);
    bsel = 1;
    go(3);
    en = 1;
    go(1);
    check("R8", "restart_oe", clk_oe_o, 1);
    check("R8", "restart_bclk_low", bclk_int_o, 0);
    check("R8", "restart_left", fclk_int_o, 0);
    bclk_period("R7", 4);

    // R9 slave pass-through
    cur_req = "R9";
    master = 0;
    for (int i = 0; i < 200; i++) begin
      ext_b = i[0];
      ext_f = ((i / 37) % 2) != 0;
      go(1);
      if (i == 100) begin
        check("R9", "oe_slave", clk_oe_o, 0);
        check("R9", "bclk_pass", bclk_int_o, ext_b ^ binv);
        check("R9", "fclk_pass", fclk_int_o, ext_f ^ finv);
      end
    end

    // R10 reset while running
    cur_req = "R10";
    master = 1;
    go(50);
    rst_n = 0;
    #1;
    check("R10", "oe_async_reset", clk_oe_o, 0);
    check("R10", "bclk_reset_idle", bclk_o, binv);
    go(3);
    rst_n = 1;
    go(40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule